// File: doc/BRIEF.md
# Two-Level Page Translation Unit

This block turns 32-bit virtual addresses into physical addresses using 4 KiB pages. An eight-entry fully associative translation cache holds recent mappings. When a lookup misses, a hardware walker reads one directory word and then one table word through a 32-bit memory read port. The walk always uses physical addresses. When the walk succeeds, the walker installs the mapping, repeats the lookup and answers from the cache. A failed walk installs nothing and returns a fault.

A client issues one translation at a time while `busy` is low. It gets one registered response pulse carrying the physical address, a writable flag and a fault flag. Control inputs cover three operations: dropping every cached mapping (optionally loading a new directory base at the same time), dropping the mapping of a single virtual page, and switching translation off so that addresses pass through unchanged. Control inputs take effect only while the block is idle.

Top module: `mmu_pager`

## Requirements
- R1: A request with `xl_en` low returns `rsp_paddr` equal to `xl_vaddr`, `rsp_writable`=1 and `rsp_fault`=0. It makes no memory read, and `rsp_valid` pulses in the second cycle after acceptance.
- R2: The virtual address splits into a directory index [31:22], a table index [21:12] and an offset [11:0]. The directory word is read at base + 4×directory index. The table word is read at (directory word & 0xFFFFF000) + 4×table index. A successful walk returns (table word & 0xFFFFF000) | offset, with `rsp_writable` equal to bit 1 of the table word.
- R3: A request to a page that is already cached completes with no memory read, and `rsp_valid` pulses in the second cycle after acceptance.
- R4: A directory word with bit 0 clear ends the walk after one read. It gives `rsp_fault`=1, `rsp_paddr`=0 and `rsp_writable`=0, and caches nothing, so the same request walks again.
- R5: A table word with bit 0 clear ends the walk after two reads with a fault and caches nothing.
- R6: A write request to a page whose table-word bit 1 is clear returns a fault. A read of that page succeeds with `rsp_writable`=0.
- R7: The cache has 8 entries. A new mapping fills the lowest free entry. When every entry is valid, victims are chosen round-robin starting from entry 0.
- R8: `ctl_flush_all` invalidates every entry. When `ctl_load_base` is also high, it loads `ctl_new_base` as the directory base.
- R9: `ctl_flush_page` invalidates only the entry whose virtual page equals `ctl_page_va[31:12]`.
- R10: While `busy` is high, flush inputs are ignored. An accepted request raises `busy` until its response.
- R11: A flush and a request in the same idle cycle: the flush is applied first, and the request looks up the flushed state.
- R12: After reset, `busy`, `rsp_valid` and `mem_req` are low. `mem_req` stays high with a stable `mem_addr` until `mem_valid`. Only one read is outstanding at a time, and `rsp_valid` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xl_req | input | 1 | Translate request, accepted when `busy` is low |
| xl_vaddr | input | 32 | Virtual address |
| xl_write | input | 1 | Request is a write access |
| xl_en | input | 1 | Translation enabled for this request |
| busy | output | 1 | A request is in progress |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_writable | output | 1 | Page allows writes |
| rsp_fault | output | 1 | Translation failed or write denied |
| ctl_flush_all | input | 1 | Invalidate all entries |
| ctl_load_base | input | 1 | With flush-all, load a new directory base |
| ctl_new_base | input | 32 | New directory base |
| ctl_flush_page | input | 1 | Invalidate one page |
| ctl_page_va | input | 32 | Address selecting the page to invalidate |
| mem_req | output | 1 | Walk read request |
| mem_addr | output | 32 | Walk read physical address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
A cache invalidation and a new translation can land in the same idle cycle. The bench provokes this by raising `ctl_flush_page` together with `xl_req` for a page that is cached at that moment. It expects a full two-read walk, not a hit, and it judges the response cycle and the read count against its model. A second collision drives flush-all with a bogus base while a walk is in flight. The bench then requires that a page cached earlier still hits with zero reads and that no new base was taken.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  localparam int VA_W  = 32;
  localparam int OFS_W = 12;
  localparam int IDX_W = 10;
  localparam int VPN_W = VA_W - OFS_W;

  typedef logic [VPN_W-1:0] vpn_t;

  typedef enum logic [1:0] {
    W_IDLE = 2'd0,
    W_LOOK = 2'd1,
    W_DIR  = 2'd2,
    W_TBL  = 2'd3
  } walk_st_e;

  typedef struct packed {
    logic vld;
    vpn_t vpn;
    vpn_t ppn;
    logic rw;
  } tlb_ent_t;
endpackage

// File: rtl/mmu_tlb.sv
module mmu_tlb import mmu_pkg::*; #(
  parameter int ENTRIES = 8
) (
  input  logic clk,
  input  logic rst,
  input  vpn_t look_vpn,
  output logic look_hit,
  output vpn_t look_ppn,
  output logic look_rw,
  input  logic ins_en,
  input  vpn_t ins_vpn,
  input  vpn_t ins_ppn,
  input  logic ins_rw,
  input  logic flush_all,
  input  logic flush_one,
  input  vpn_t flush_vpn
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  tlb_ent_t ent [ENTRIES];
  logic [ENTRIES-1:0] hit_v, dup_v, free_v, kill_v;
  logic [PTR_W-1:0] rr_q, free_idx;
  logic any_free;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_v[g]  = ent[g].vld && (ent[g].vpn == look_vpn);
    assign dup_v[g]  = ent[g].vld && (ent[g].vpn == ins_vpn);
    assign free_v[g] = !ent[g].vld;
    assign kill_v[g] = flush_all || (flush_one && ent[g].vld && (ent[g].vpn == flush_vpn));
  end

  assign look_hit = |hit_v;
  assign any_free = |free_v;

  always_comb begin
    look_ppn = '0;
    look_rw  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_v[i]) begin
        look_ppn = look_ppn | ent[i].ppn;
        look_rw  = look_rw | ent[i].rw;
      end
    end
  end

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (free_v[i]) free_idx = PTR_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) ent[i].vld <= 1'b0;
      rr_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (kill_v[i]) ent[i].vld <= 1'b0;
      end
      if (ins_en && !(|dup_v)) begin
        if (any_free) begin
          ent[free_idx] <= '{vld: 1'b1, vpn: ins_vpn, ppn: ins_ppn, rw: ins_rw};
        end else begin
          ent[rr_q] <= '{vld: 1'b1, vpn: ins_vpn, ppn: ins_ppn, rw: ins_rw};
          rr_q      <= (rr_q == LAST) ? '0 : rr_q + PTR_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/mmu_walk.sv
module mmu_walk import mmu_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             xl_req,
  input  logic [VA_W-1:0]  xl_vaddr,
  input  logic             xl_write,
  input  logic             xl_en,
  output logic             busy,
  output logic             rsp_valid,
  output logic [VA_W-1:0]  rsp_paddr,
  output logic             rsp_writable,
  output logic             rsp_fault,
  input  logic [VA_W-1:0]  dir_base,
  output vpn_t             look_vpn,
  input  logic             look_hit,
  input  vpn_t             look_ppn,
  input  logic             look_rw,
  output logic             ins_en,
  output vpn_t             ins_vpn,
  output vpn_t             ins_ppn,
  output logic             ins_rw,
  output logic             mem_req,
  output logic [VA_W-1:0]  mem_addr,
  input  logic             mem_valid,
  input  logic [VA_W-1:0]  mem_rdata
);
  walk_st_e st_q;
  logic [VA_W-1:0] va_q;
  logic wr_q, en_q, retried_q;
  logic unused_bits;

  assign unused_bits = ^mem_rdata[OFS_W-1:2];
  assign busy        = (st_q != W_IDLE);
  assign look_vpn    = va_q[VA_W-1:OFS_W];

  assign ins_en  = (st_q == W_TBL) && mem_valid && mem_rdata[0];
  assign ins_vpn = va_q[VA_W-1:OFS_W];
  assign ins_ppn = mem_rdata[VA_W-1:OFS_W];
  assign ins_rw  = mem_rdata[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= W_IDLE;
      va_q         <= '0;
      wr_q         <= 1'b0;
      en_q         <= 1'b0;
      retried_q    <= 1'b0;
      rsp_valid    <= 1'b0;
      rsp_paddr    <= '0;
      rsp_writable <= 1'b0;
      rsp_fault    <= 1'b0;
      mem_req      <= 1'b0;
      mem_addr     <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st_q)
        W_IDLE: begin
          if (xl_req) begin
            va_q      <= xl_vaddr;
            wr_q      <= xl_write;
            en_q      <= xl_en;
            retried_q <= 1'b0;
            st_q      <= W_LOOK;
          end
        end
        W_LOOK: begin
          if (!en_q) begin
            rsp_valid    <= 1'b1;
            rsp_paddr    <= va_q;
            rsp_writable <= 1'b1;
            rsp_fault    <= 1'b0;
            st_q         <= W_IDLE;
          end else if (look_hit) begin
            rsp_valid    <= 1'b1;
            rsp_writable <= look_rw;
            rsp_fault    <= wr_q && !look_rw;
            rsp_paddr    <= (wr_q && !look_rw) ? '0 : {look_ppn, va_q[OFS_W-1:0]};
            st_q         <= W_IDLE;
          end else if (retried_q) begin
            rsp_valid    <= 1'b1;
            rsp_paddr    <= '0;
            rsp_writable <= 1'b0;
            rsp_fault    <= 1'b1;
            st_q         <= W_IDLE;
          end else begin
            mem_req  <= 1'b1;
            mem_addr <= dir_base + VA_W'({va_q[VA_W-1 -: IDX_W], 2'b00});
            st_q     <= W_DIR;
          end
        end
        W_DIR: begin
          if (mem_valid) begin
            if (!mem_rdata[0]) begin
              mem_req      <= 1'b0;
              rsp_valid    <= 1'b1;
              rsp_paddr    <= '0;
              rsp_writable <= 1'b0;
              rsp_fault    <= 1'b1;
              st_q         <= W_IDLE;
            end else begin
              mem_addr <= {mem_rdata[VA_W-1:OFS_W], {OFS_W{1'b0}}}
                          + VA_W'({va_q[OFS_W +: IDX_W], 2'b00});
              st_q     <= W_TBL;
            end
          end
        end
        W_TBL: begin
          if (mem_valid) begin
            mem_req <= 1'b0;
            if (!mem_rdata[0]) begin
              rsp_valid    <= 1'b1;
              rsp_paddr    <= '0;
              rsp_writable <= 1'b0;
              rsp_fault    <= 1'b1;
              st_q         <= W_IDLE;
            end else begin
              retried_q <= 1'b1;
              st_q      <= W_LOOK;
            end
          end
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mmu_pager.sv
module mmu_pager import mmu_pkg::*; #(
  parameter int              TLB_ENTRIES = 8,
  parameter logic [VA_W-1:0] BASE_RESET  = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            xl_req,
  input  logic [VA_W-1:0] xl_vaddr,
  input  logic            xl_write,
  input  logic            xl_en,
  output logic            busy,
  output logic            rsp_valid,
  output logic [VA_W-1:0] rsp_paddr,
  output logic            rsp_writable,
  output logic            rsp_fault,
  input  logic            ctl_flush_all,
  input  logic            ctl_load_base,
  input  logic [VA_W-1:0] ctl_new_base,
  input  logic            ctl_flush_page,
  input  logic [VA_W-1:0] ctl_page_va,
  output logic            mem_req,
  output logic [VA_W-1:0] mem_addr,
  input  logic            mem_valid,
  input  logic [VA_W-1:0] mem_rdata
);
  logic [VA_W-1:0] base_q;
  logic fl_all, fl_one;
  vpn_t look_vpn, look_ppn, ins_vpn, ins_ppn;
  logic look_hit, look_rw, ins_en, ins_rw;
  logic unused_top;

  assign unused_top = ^ctl_page_va[OFS_W-1:0];
  assign fl_all     = ctl_flush_all && !busy;
  assign fl_one     = ctl_flush_page && !busy;

  always_ff @(posedge clk) begin
    if (rst) base_q <= BASE_RESET;
    else if (fl_all && ctl_load_base) base_q <= ctl_new_base;
  end

  mmu_tlb #(.ENTRIES(TLB_ENTRIES)) i_tlb (
    .clk(clk), .rst(rst),
    .look_vpn(look_vpn), .look_hit(look_hit), .look_ppn(look_ppn), .look_rw(look_rw),
    .ins_en(ins_en), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn), .ins_rw(ins_rw),
    .flush_all(fl_all), .flush_one(fl_one), .flush_vpn(ctl_page_va[VA_W-1:OFS_W])
  );

  mmu_walk i_walk (
    .clk(clk), .rst(rst),
    .xl_req(xl_req), .xl_vaddr(xl_vaddr), .xl_write(xl_write), .xl_en(xl_en),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_writable(rsp_writable), .rsp_fault(rsp_fault),
    .dir_base(base_q),
    .look_vpn(look_vpn), .look_hit(look_hit), .look_ppn(look_ppn), .look_rw(look_rw),
    .ins_en(ins_en), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn), .ins_rw(ins_rw),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata)
  );
endmodule

// File: rtl/mmu_pager_chk.sv
module mmu_pager_chk (
  input logic        clk,
  input logic        rst,
  input logic        xl_req,
  input logic        busy,
  input logic        rsp_valid,
  input logic [31:0] rsp_paddr,
  input logic        rsp_writable,
  input logic        rsp_fault,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_valid
);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  // R12
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R12
  req_in_walk_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  // R4
  fault_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == 32'h0 && !rsp_writable));

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && xl_req) |=> busy);

  // R10
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !busy);
endmodule

bind mmu_pager mmu_pager_chk i_chk (.*);

// File: tb/test_mmu_pager.sv
module test_mmu_pager;
  localparam int CLK_PERIOD = 10;
  localparam int NENT = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xl_req = 1'b0, xl_write = 1'b0, xl_en = 1'b0;
  logic [31:0] xl_vaddr = '0;
  logic busy, rsp_valid, rsp_writable, rsp_fault;
  logic [31:0] rsp_paddr;
  logic ctl_flush_all = 1'b0, ctl_load_base = 1'b0, ctl_flush_page = 1'b0;
  logic [31:0] ctl_new_base = '0, ctl_page_va = '0;
  logic mem_req, mem_valid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmu_pager i_mmu_pager (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  // physical memory and read port model
  logic [31:0] pmem [logic [31:0]];
  int mem_lat = 0, mem_cnt = 0, mem_reads = 0;

  function automatic logic [31:0] rdmem(input logic [31:0] a);
    return pmem.exists(a) ? pmem[a] : 32'h0;
  endfunction

  always @(negedge clk) begin
    if (mem_valid) begin
      mem_valid = 1'b0;
      mem_cnt = 0;
    end else if (mem_req) begin
      if (mem_cnt == mem_lat) begin
        mem_valid = 1'b1;
        mem_rdata = rdmem(mem_addr);
        mem_reads++;
        mem_cnt = 0;
      end else mem_cnt++;
    end else mem_cnt = 0;
  end

  // reference translation cache
  logic        m_vld [NENT];
  logic [19:0] m_vpn [NENT];
  logic [19:0] m_ppn [NENT];
  logic        m_rw  [NENT];
  int          m_rr = 0;
  logic [31:0] m_base = '0;

  function automatic void m_flush_all();
    for (int i = 0; i < NENT; i++) m_vld[i] = 1'b0;
  endfunction

  function automatic void m_flush_page(input logic [31:0] va);
    for (int i = 0; i < NENT; i++)
      if (m_vld[i] && m_vpn[i] == va[31:12]) m_vld[i] = 1'b0;
  endfunction

  function automatic int m_find(input logic [19:0] vpn);
    for (int i = 0; i < NENT; i++) if (m_vld[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  function automatic void m_insert(input logic [19:0] vpn, input logic [19:0] ppn, input logic rw);
    int slot = -1;
    for (int i = NENT - 1; i >= 0; i--) if (!m_vld[i]) slot = i;
    if (slot < 0) begin
      slot = m_rr;
      m_rr = (m_rr + 1) % NENT;
    end
    m_vld[slot] = 1'b1; m_vpn[slot] = vpn; m_ppn[slot] = ppn; m_rw[slot] = rw;
  endfunction

  task automatic predict(input logic [31:0] va, input logic wr, input logic en,
                         output logic [31:0] pa, output logic w, output logic f,
                         output int k, output int rd);
    int hit;
    logic [31:0] d, t;
    rd = 0;
    if (!en) begin pa = va; w = 1; f = 0; k = 1; return; end
    hit = m_find(va[31:12]);
    k = 1;
    if (hit < 0) begin
      d = rdmem(m_base + {20'h0, va[31:22], 2'b00});
      rd = 1;
      if (!d[0]) begin pa = 0; w = 0; f = 1; k = mem_lat + 2; return; end
      t = rdmem({d[31:12], 12'h0} + {20'h0, va[21:12], 2'b00});
      rd = 2;
      if (!t[0]) begin pa = 0; w = 0; f = 1; k = 2*mem_lat + 4; return; end
      m_insert(va[31:12], t[31:12], t[1]);
      hit = m_find(va[31:12]);
      k = 2*mem_lat + 5;
    end
    w = m_rw[hit];
    f = wr && !m_rw[hit];
    pa = f ? 32'h0 : {m_ppn[hit], va[11:0]};
  endtask

  task automatic xlate(input logic [31:0] va, input logic wr, input logic en,
                       input logic fp, input logic [31:0] fpva, input string rq);
    logic [31:0] epa; logic ew, ef; int ek, erd, r0;
    if (fp) m_flush_page(fpva);
    predict(va, wr, en, epa, ew, ef, ek, erd);
    @(negedge clk);
    r0 = mem_reads;
    xl_req = 1; xl_vaddr = va; xl_write = wr; xl_en = en;
    ctl_flush_page = fp; ctl_page_va = fpva;
    @(negedge clk);
    xl_req = 0; ctl_flush_page = 0;
    for (int c = 1; c <= ek; c++) begin
      @(negedge clk);
      if (c < ek) begin
        if (rsp_valid) chk(0, rq, "early rsp_valid", 32'(c), 32'(ek));
      end else begin
        chk(rsp_valid === 1'b1, rq, "rsp_valid", {31'h0, rsp_valid}, 32'h1);
        chk(rsp_paddr === epa, rq, "rsp_paddr", rsp_paddr, epa);
        chk(rsp_writable === ew, rq, "rsp_writable", {31'h0, rsp_writable}, {31'h0, ew});
        chk(rsp_fault === ef, rq, "rsp_fault", {31'h0, rsp_fault}, {31'h0, ef});
        chk(mem_reads - r0 == erd, rq, "read count", 32'(mem_reads - r0), 32'(erd));
      end
    end
  endtask

  task automatic flush_all(input logic ld, input logic [31:0] nb);
    @(negedge clk);
    ctl_flush_all = 1; ctl_load_base = ld; ctl_new_base = nb;
    @(negedge clk);
    ctl_flush_all = 0; ctl_load_base = 0;
    m_flush_all();
    if (ld) m_base = nb;
  endtask

  task automatic flush_page(input logic [31:0] va);
    @(negedge clk);
    ctl_flush_page = 1; ctl_page_va = va;
    @(negedge clk);
    ctl_flush_page = 0;
    m_flush_page(va);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp<50000", cyc);
      finish_run();
    end
  end

  initial begin
    m_flush_all();
    // tables, base B0
    pmem[32'h0001_0004] = 32'h0002_0001;
    pmem[32'h0001_0008] = 32'h0003_0FF0;
    pmem[32'h0001_000C] = 32'h0004_0001;
    for (int i = 0; i < 12; i++) pmem[32'h0002_0000 + 4*i] = 32'h0100_0003 + (i << 12);
    pmem[32'h0002_000C] = 32'h0300_0001;
    pmem[32'h0002_0014] = 32'h0500_0002;
    pmem[32'h0004_001C] = 32'h0777_7003;
    // tables, base B1
    pmem[32'h0005_0004] = 32'h0006_0001;
    pmem[32'h0006_0000] = 32'h0AAA_A001;

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy === 0, "R12", "reset busy", {31'h0, busy}, 0);
    chk(rsp_valid === 0, "R12", "reset rsp_valid", {31'h0, rsp_valid}, 0);
    chk(mem_req === 0, "R12", "reset mem_req", {31'h0, mem_req}, 0);

    xlate(32'h1234_5678, 1, 0, 0, 0, "R1");
    flush_all(1, 32'h0001_0000);                       // R8 load
    xlate(32'h0040_0ABC, 0, 1, 0, 0, "R2");
    xlate(32'h0040_0FFC, 1, 1, 0, 0, "R3");
    xlate(32'h0040_3010, 1, 1, 0, 0, "R6");
    xlate(32'h0040_3010, 0, 1, 0, 0, "R6");
    xlate(32'h0080_1000, 0, 1, 0, 0, "R4");
    xlate(32'h0080_1000, 0, 1, 0, 0, "R4");
    xlate(32'h0040_5000, 0, 1, 0, 0, "R5");
    xlate(32'h0040_5000, 0, 1, 0, 0, "R5");
    mem_lat = 2;
    xlate(32'h00C0_7444, 0, 1, 0, 0, "R12");
    mem_lat = 0;

    flush_page(32'h0040_3FFF);                         // R9
    xlate(32'h0040_3010, 0, 1, 0, 0, "R9");
    xlate(32'h0040_0000, 0, 1, 0, 0, "R9");
    xlate(32'h00C0_7000, 0, 1, 0, 0, "R9");

    for (int p = 0; p < 2; p++)                        // R7
      for (int i = 0; i < 12; i++)
        if (i != 3 && i != 5) xlate(32'h0040_0000 | (i << 12), 0, 1, 0, 0, "R7");
    xlate(32'h00C0_7000, 0, 1, 0, 0, "R7");

    xlate(32'h0040_B000, 0, 1, 0, 0, "R11");
    xlate(32'h0040_B000, 0, 1, 1, 32'h0040_B123, "R11");

    fork                                               // R10
      xlate(32'h0080_1000, 0, 1, 0, 0, "R10");
      begin
        repeat (2) @(negedge clk);
        ctl_flush_all = 1; ctl_load_base = 1; ctl_new_base = 32'hDEAD_0000;
        @(negedge clk);
        ctl_flush_all = 0; ctl_load_base = 0;
      end
    join
    xlate(32'h0040_B000, 0, 1, 0, 0, "R10");
    xlate(32'h00C0_7010, 0, 1, 0, 0, "R10");

    flush_all(1, 32'h0005_0000);
    xlate(32'h0040_0123, 0, 1, 0, 0, "R8");
    xlate(32'h00C0_7000, 0, 1, 0, 0, "R8");
    flush_all(0, 32'h0);
    xlate(32'h0040_0123, 0, 1, 0, 0, "R8");
    xlate(32'h0040_0123, 1, 1, 0, 0, "R6");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule